// File: doc/BRIEF.md
# Serial Key Configuration Loader

The loader fills a set of key registers from a single serial input that is sampled on every rising clock edge while a mode input is high. Each configuration begins with a 4-bit size field `n`. Two key fields follow it, the exponent and then the modulus, and each of them is `2**n` bits wide. Because the field widths are carried inside the stream, the block works out how many bits to capture while the load is still in progress. A complete stream therefore spans `2**(n+1)+4` clock cycles.

The exponent and modulus registers are sized for the largest legal `n`. Each field is sent most significant bit first and lands right-aligned in its register, and every bit above it reads zero. The size field must lie from 3 to 10. A value outside that range raises an error flag, and the rest of that stream is ignored. A ready flag marks a complete key set. Whether the key values themselves are sound is left to the consumer.

Top module: `key_cfg_loader`

## Requirements
- R1: While `rst_n` is low, `cfg_ready` and `size_err` are 0 and `key_size`, `key_exp` and `key_mod` are all zero.
- R2: A configuration starts on the first rising edge at which `cfg_mode` is 1 while the loader is idle (after reset or after `cfg_mode` was 0). That edge samples bit 3 of the size field, and the next three edges sample bits 2, 1 and 0, most significant first.
- R3: For a legal size `n`, the next `2**n` edges shift in the exponent MSB first, and the `2**n` edges after those shift in the modulus MSB first. `key_size` then equals `n`, and `key_exp` and `key_mod` equal the sent values.
- R4: `cfg_ready` is 0 through the edge that samples the last modulus bit and is 1 right after that edge.
- R5: Once a key set is loaded, every bit of `key_exp` and `key_mod` at position `2**n` or above is zero.
- R6: A size field below 3 or above 10 sets `size_err` on the edge that samples its last bit. `key_size` shows the received field, `cfg_ready` stays 0, and `key_exp` and `key_mod` stay zero whatever bits follow while `cfg_mode` stays high.
- R7: After a complete load, `cfg_ready` stays 1 and the key registers keep their values. This holds while extra bits arrive with `cfg_mode` high and after `cfg_mode` returns to 0.
- R8: The start edge of a new configuration clears `cfg_ready`, `size_err` and both key registers.
- R9: If `cfg_mode` drops before the last modulus bit, the load is abandoned and `cfg_ready` stays 0. The next rise of `cfg_mode` restarts from the size field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the serial input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | 1 selects loading, 0 selects normal operation |
| cfg_bit | input | 1 | Serial configuration data |
| key_size | output | SIZE_W (4) | Size field of the latest configuration |
| key_exp | output | 2**N_MAX (1024) | Exponent, right-aligned |
| key_mod | output | 2**N_MAX (1024) | Modulus, right-aligned |
| cfg_ready | output | 1 | A complete key set is held |
| size_err | output | 1 | The latest size field was out of range |

## Verification
The bench sweeps every one of the sixteen size codes and sends each field as a distinct arithmetic bit pattern. Four kinds of fault are targeted:

- An off-by-one bit counter would shift every field and corrupt the highest bit compared.
- A ready flag raised one edge early would be seen on the cycle of the last modulus bit.
- A wrong range test at 2, 3, 10 or 11 would flip `size_err`, or would load junk into the key registers.
- Failing to clear on restart would leave stale high bits from a longer earlier key.

An abandoned load followed by a shorter one checks that the restart and the clearing both happen.

// File: rtl/keyld_pkg.sv
package keyld_pkg;
   typedef enum logic [2:0] {
      LD_IDLE,
      LD_SIZE,
      LD_EXP,
      LD_MOD,
      LD_HOLD,
      LD_ERR
   } ld_state_t;
endpackage

// File: rtl/keyld_size_chk.sv
module keyld_size_chk #(
   parameter int SIZE_W = 4,
   parameter int N_MIN  = 3,
   parameter int N_MAX  = 10
) (
   input  logic [SIZE_W-1:0] size,
   output logic              legal
);
   always_comb begin
      legal = (int'(size) >= N_MIN) && (int'(size) <= N_MAX);
   end
endmodule

// File: rtl/keyld_shift.sv
module keyld_shift #(
   parameter int W = 1024
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] q
);
   generate
      if (W < 2) begin : g_bad
         $error("keyld_shift: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (clr)
         q <= '0;
      else if (en)
         q <= {q[W-2:0], din};
   end
endmodule

// File: rtl/keyld_ctrl.sv
module keyld_ctrl
   import keyld_pkg::*;
#(
   parameter int SIZE_W = 4,
   parameter int N_MIN  = 3,
   parameter int N_MAX  = 10,
   localparam int CNT_W = N_MAX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              cfg_bit,
   output logic [SIZE_W-1:0] size_q,
   output logic              ready,
   output logic              err,
   output logic              clr,
   output logic              exp_en,
   output logic              mod_en
);
   ld_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  last_idx;
   logic [SIZE_W-1:0] cand;
   logic              cand_legal;
   logic              stored_legal;

   assign cand = {size_q[SIZE_W-2:0], cfg_bit};

   keyld_size_chk #(.SIZE_W(SIZE_W), .N_MIN(N_MIN), .N_MAX(N_MAX))
      u_cand_chk (.size(cand), .legal(cand_legal));

   keyld_size_chk #(.SIZE_W(SIZE_W), .N_MIN(N_MIN), .N_MAX(N_MAX))
      u_len_chk (.size(size_q), .legal(stored_legal));

   // Index of the last bit of a field: 2**size - 1 as a mask of ones.
   always_comb begin
      last_idx = '0;
      for (int b = 0; b < CNT_W; b++)
         if (b < int'(size_q)) last_idx[b] = 1'b1;
   end

   always_comb begin
      clr    = cfg_mode && (state == LD_IDLE);
      exp_en = cfg_mode && (state == LD_EXP);
      mod_en = cfg_mode && (state == LD_MOD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= LD_IDLE;
         cnt    <= '0;
         size_q <= '0;
         ready  <= 1'b0;
         err    <= 1'b0;
      end else if (!cfg_mode) begin
         state <= LD_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            LD_IDLE: begin
               size_q <= {{(SIZE_W-1){1'b0}}, cfg_bit};
               cnt    <= CNT_W'(1);
               ready  <= 1'b0;
               err    <= 1'b0;
               state  <= LD_SIZE;
            end
            LD_SIZE: begin
               size_q <= cand;
               if (cnt == CNT_W'(SIZE_W - 1)) begin
                  cnt   <= '0;
                  err   <= !cand_legal;
                  state <= cand_legal ? LD_EXP : LD_ERR;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            LD_EXP: begin
               if (cnt == last_idx) begin
                  cnt   <= '0;
                  state <= LD_MOD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            LD_MOD: begin
               if (cnt == last_idx) begin
                  cnt   <= '0;
                  ready <= 1'b1;
                  state <= LD_HOLD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= state;
         endcase
      end
   end

   // R3
   len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LD_EXP || state == LD_MOD) |-> stored_legal);

   // R4
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(state) == LD_MOD));

   // R8
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> ($past(cfg_mode) && $past(state) == LD_IDLE));

   // R6
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && err));
endmodule

// File: rtl/key_cfg_loader.sv
module key_cfg_loader #(
   parameter int SIZE_W = 4,
   parameter int N_MIN  = 3,
   parameter int N_MAX  = 10,
   localparam int KEY_W = 1 << N_MAX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              cfg_bit,
   output logic [SIZE_W-1:0] key_size,
   output logic [KEY_W-1:0]  key_exp,
   output logic [KEY_W-1:0]  key_mod,
   output logic              cfg_ready,
   output logic              size_err
);
   generate
      if (SIZE_W < 2 || N_MAX >= (1 << SIZE_W)) begin : g_bad_size
         $error("key_cfg_loader: N_MAX must fit in the size field");
      end
      if (N_MIN < 1 || N_MIN > N_MAX) begin : g_bad_range
         $error("key_cfg_loader: need 1 <= N_MIN <= N_MAX");
      end
   endgenerate

   logic clr, exp_en, mod_en;

   keyld_ctrl #(.SIZE_W(SIZE_W), .N_MIN(N_MIN), .N_MAX(N_MAX)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_mode(cfg_mode),
      .cfg_bit (cfg_bit),
      .size_q  (key_size),
      .ready   (cfg_ready),
      .err     (size_err),
      .clr     (clr),
      .exp_en  (exp_en),
      .mod_en  (mod_en)
   );

   keyld_shift #(.W(KEY_W)) u_exp (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(exp_en), .din(cfg_bit), .q(key_exp)
   );

   keyld_shift #(.W(KEY_W)) u_mod (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(mod_en), .din(cfg_bit), .q(key_mod)
   );

   // R5
   high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ready |-> (((key_exp >> (1 << key_size)) == '0) &&
                     ((key_mod >> (1 << key_size)) == '0)));

   // R6
   err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_err && $past(size_err)) |-> ($stable(key_exp) && $stable(key_mod)));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ready && $past(cfg_ready)) |->
         ($stable(key_exp) && $stable(key_mod) && $stable(key_size)));
endmodule

// File: tb/test_key_cfg_loader.sv
`timescale 1ns/1ps
module test_key_cfg_loader;
   localparam int KW = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_mode = 1'b0;
   logic          cfg_bit = 1'b0;
   logic [3:0]    key_size;
   logic [KW-1:0] key_exp;
   logic [KW-1:0] key_mod;
   logic          cfg_ready;
   logic          size_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   key_cfg_loader i_key_cfg_loader (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bit(cfg_bit),
      .key_size(key_size), .key_exp(key_exp), .key_mod(key_mod),
      .cfg_ready(cfg_ready), .size_err(size_err)
   );

   task automatic chk(input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [KW-1:0] make_pat(input int n, input int seed);
      logic [KW-1:0] p = '0;
      for (int i = 0; i < (1 << n); i++)
         p[i] = (((i * seed) + (i >> 2) + n) % 5) < 2;
      return p;
   endfunction

   // Sends a configuration for size code n; abort_at >= 0 drops mode before that bit.
   task automatic load(input int n, input int abort_at);
      int len = (n >= 3 && n <= 10) ? (1 << n) : 0;
      bit legal = (len != 0);
      int total = legal ? (4 + 2 * len) : 44;
      logic [KW-1:0] pe = legal ? make_pat(n, 7) : '0;
      logic [KW-1:0] pm = legal ? make_pat(n, 13) : '0;
      logic [3:0] nb = 4'(n);
      for (int k = 0; k < total; k++) begin
         @(negedge clk);
         if (k == abort_at) begin
            cfg_mode = 1'b0;
            repeat (3) @(negedge clk);
            chk("R9 ready after abort", KW'(cfg_ready), KW'(0));
            chk("R9 err after abort", KW'(size_err), KW'(0));
            return;
         end
         if (k == 1) begin
            chk("R8 ready cleared at start", KW'(cfg_ready), KW'(0));
            chk("R8 err cleared at start", KW'(size_err), KW'(0));
            chk("R8 exp cleared at start", key_exp, '0);
            chk("R8 mod cleared at start", key_mod, '0);
         end
         if (legal && k == total - 1)
            chk("R4 ready before last edge", KW'(cfg_ready), KW'(0));
         cfg_mode = 1'b1;
         if (k < 4)
            cfg_bit = nb[3-k];
         else if (!legal)
            cfg_bit = ((k * 3) % 7) < 3;
         else if (k < 4 + len)
            cfg_bit = pe[len-1-(k-4)];
         else
            cfg_bit = pm[len-1-(k-4-len)];
      end
      @(negedge clk);
      if (legal) begin
         chk("R4 ready after last edge", KW'(cfg_ready), KW'(1));
         chk("R3 exp value", key_exp, pe);
         chk("R3 mod value", key_mod, pm);
         chk("R3 size value", KW'(key_size), KW'(n));
         chk("R5 exp high bits", key_exp >> len, '0);
         chk("R5 mod high bits", key_mod >> len, '0);
         for (int j = 0; j < 8; j++) begin
            cfg_bit = j[0];
            @(negedge clk);
         end
         chk("R7 exp after extra bits", key_exp, pe);
         chk("R7 mod after extra bits", key_mod, pm);
         chk("R7 ready after extra bits", KW'(cfg_ready), KW'(1));
      end else begin
         chk("R6 err set", KW'(size_err), KW'(1));
         chk("R6 ready low", KW'(cfg_ready), KW'(0));
         chk("R6 exp zero", key_exp, '0);
         chk("R6 mod zero", key_mod, '0);
         chk("R6 size shows field", KW'(key_size), KW'(n));
      end
      cfg_mode = 1'b0;
      repeat (3) @(negedge clk);
      chk(legal ? "R7 ready after mode low" : "R6 err after mode low",
          KW'(legal ? cfg_ready : size_err), KW'(1));
      chk("R7 exp after mode low", key_exp, pe);
      chk("R7 mod after mode low", key_mod, pm);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", KW'(cfg_ready), KW'(0));
      chk("R1 err in reset", KW'(size_err), KW'(0));
      chk("R1 size in reset", KW'(key_size), KW'(0));
      chk("R1 exp in reset", key_exp, '0);
      chk("R1 mod in reset", key_mod, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R2 R3 R6: sweep of every size code
      for (int n = 0; n < 16; n++) load(n, -1);
      // R9: abandon a long load, then a shorter one must come out clean
      load(9, 300);
      load(4, -1);
      load(10, 1500);
      load(3, -1);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule